// File: doc/BRIEF.md
# RTC 32 kHz Clock Selector

This block builds the low-speed clock tree of a real-time-clock domain. All work happens in one system clock domain, and every clock is a one-cycle enable pulse. A fast internal oscillator is represented by `fast_tick`. It passes through a fixed prescaler of 32 and then through a programmable divider of (N+1). A 24 MHz reference, represented by `ref_tick`, passes through a fixed divide by 750. An optional external 32 kHz crystal, represented by `xtal_tick`, can be gated in.

Two selects pick the clocks. The first chooses the low-speed oscillator from the internal divided clock or the gated crystal. The second chooses the RTC clock from the low-speed oscillator or the reference-derived clock. A separately gated fan-out output picks one of three of these sources.

Software programs the block through a 32-bit register port. Reads are combinational and writes complete in a single cycle. The control register accepts a write only when the write data carries a fixed key in its upper half.

Top module: `rtc32k_clk_sel`

## Requirements
- R1: After reset every register reads 0 and no output pulses while no source is enabled.
- R2: A write to the control register at offset 0x0 takes effect only when write data bits 31:16 equal 0x16AA. Otherwise the register keeps its value. Reads of it return 0 in bits 31:16.
- R3: With the fast source enabled, the internal low-speed path emits one pulse for every 32*(N+1) `fast_tick` pulses. N is bits 4:0 of offset 0x8. The pulse appears in the same cycle as the 32*(N+1)-th tick counted from a restart.
- R4: Bit 0 of offset 0x160 enables the fast source. While it is 0, the internal path gives no pulses and its count returns to zero.
- R5: Any write to offset 0x8 restarts the internal divider count from zero.
- R6: Bit 16 of offset 0x60 gates the reference path. While it is set, the path pulses in the cycle of every 750th `ref_tick` counted from when the gate opened. While it is clear, the path gives no pulses.
- R7: Control bit 0 selects the low-speed oscillator: 0 gives the internal divided clock, 1 gives `xtal_tick` gated by control bit 4.
- R8: Control bit 1 selects the RTC clock: 0 gives the low-speed oscillator, 1 gives the reference-derived clock.
- R9: Bit 0 of offset 0x60 enables the fan-out output. Bits 2:1 choose its source: 0 gives the low-speed oscillator, 1 gives the gated crystal, 2 gives the reference-derived clock, and 3 drives it low.
- R10: Unimplemented register bits and unmapped offsets read as zero. Offset 0x8 keeps only bits 4:0, and offset 0x160 keeps only bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fast_tick | input | 1 | One pulse per fast internal oscillator cycle |
| ref_tick | input | 1 | One pulse per 24 MHz reference cycle |
| xtal_tick | input | 1 | One pulse per external crystal cycle |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| losc_clk_en | output | 1 | Low-speed oscillator pulse |
| rtc_clk_en | output | 1 | RTC clock pulse |
| fanout_clk_en | output | 1 | Fan-out clock pulse |

## Verification
Some properties are checked by assertions on every cycle:
- A control write without the key leaves the selects unchanged.
- A disabled fast source or a closed reference gate yields no pulses.
- The RTC and fan-out outputs only ever carry a pulse from their selected source.

Other behaviour needs a scenario to show it: the exact divide ratios, the cycle of the first pulse after a restart, the effect of a reserved fan-out select, and readback masking. The bench's directed tasks count pulses over known tick windows to cover these.

// File: rtl/rtc32k_pkg.sv
package rtc32k_pkg;
    localparam int          ADDR_W   = 9;
    localparam int          DATA_W   = 32;
    localparam logic [8:0]  OFF_CTRL = 9'h000;
    localparam logic [8:0]  OFF_DIV  = 9'h008;
    localparam logic [8:0]  OFF_GATE = 9'h060;
    localparam logic [8:0]  OFF_OSC  = 9'h160;
    localparam logic [15:0] CTRL_KEY = 16'h16AA;

    typedef enum logic [1:0] {
        FO_LOSC = 2'd0,
        FO_XTAL = 2'd1,
        FO_REF  = 2'd2,
        FO_NONE = 2'd3
    } fo_src_e;

    typedef struct packed {
        logic xtal_gate;
        logic rtc_sel;
        logic losc_sel;
    } ctrl_t;

    typedef struct packed {
        logic    ref_gate;
        fo_src_e fo_src;
        logic    fo_en;
    } gate_t;
endpackage

// File: rtl/rtc32k_regs.sv
module rtc32k_regs
    import rtc32k_pkg::*;
#(
    parameter int DIVN_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output ctrl_t             ctrl_o,
    output gate_t             gate_o,
    output logic [DIVN_W-1:0] divn_o,
    output logic              fast_en_o,
    output logic              div_wr_o
);
    typedef struct packed {
        ctrl_t             ctrl;
        gate_t             gate;
        logic [DIVN_W-1:0] divn;
        logic              fast_en;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  unused_wbits;

    assign unused_wbits = ^wdata;

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            unique case (addr)
                OFF_CTRL: if (wdata[31:16] == CTRL_KEY) begin
                    regs_d.ctrl.losc_sel  = wdata[0];
                    regs_d.ctrl.rtc_sel   = wdata[1];
                    regs_d.ctrl.xtal_gate = wdata[4];
                end
                OFF_DIV:  regs_d.divn = wdata[DIVN_W-1:0];
                OFF_GATE: begin
                    regs_d.gate.fo_en    = wdata[0];
                    regs_d.gate.fo_src   = fo_src_e'(wdata[2:1]);
                    regs_d.gate.ref_gate = wdata[16];
                end
                OFF_OSC:  regs_d.fast_en = wdata[0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            OFF_CTRL: begin
                rdata[0] = regs_q.ctrl.losc_sel;
                rdata[1] = regs_q.ctrl.rtc_sel;
                rdata[4] = regs_q.ctrl.xtal_gate;
            end
            OFF_DIV:  rdata[DIVN_W-1:0] = regs_q.divn;
            OFF_GATE: begin
                rdata[0]   = regs_q.gate.fo_en;
                rdata[2:1] = regs_q.gate.fo_src;
                rdata[16]  = regs_q.gate.ref_gate;
            end
            OFF_OSC:  rdata[0] = regs_q.fast_en;
            default:  ;
        endcase
    end

    assign ctrl_o    = regs_q.ctrl;
    assign gate_o    = regs_q.gate;
    assign divn_o    = regs_q.divn;
    assign fast_en_o = regs_q.fast_en;
    assign div_wr_o  = we && (addr == OFF_DIV);
endmodule

// File: rtl/rtc32k_fast_div.sv
module rtc32k_fast_div #(
    parameter int PRE_DIV = 32,
    parameter int DIVN_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              restart,
    input  logic              tick,
    input  logic [DIVN_W-1:0] divn,
    output logic              pulse
);
    localparam int              PRE_W   = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(PRE_DIV - 1);

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [DIVN_W-1:0] post;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic pre_wrap;

    assign pre_wrap = tick && (cnt_q.pre == PRE_TOP);
    assign pulse    = en && pre_wrap && (cnt_q.post == divn);

    always_comb begin
        cnt_d = cnt_q;
        if (!en || restart) begin
            cnt_d = '0;
        end else if (tick) begin
            if (pre_wrap) begin
                cnt_d.pre  = '0;
                cnt_d.post = (cnt_q.post == divn) ? '0 : cnt_q.post + 1'b1;
            end else begin
                cnt_d.pre = cnt_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rtc32k_fixed_div.sv
module rtc32k_fixed_div #(
    parameter int DIV = 750
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    output logic pulse
);
    localparam int           CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] TOP = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign pulse = en && tick && (cnt_q == TOP);

    always_comb begin
        cnt_d = cnt_q;
        if (!en)       cnt_d = '0;
        else if (tick) cnt_d = (cnt_q == TOP) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rtc32k_clk_sel.sv
module rtc32k_clk_sel
    import rtc32k_pkg::*;
#(
    parameter int PRE_DIV      = 32,
    parameter int DIVN_W       = 5,
    parameter int REF_DIV      = 750,
    parameter bit HAS_EXT_XTAL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_tick,
    input  logic              ref_tick,
    input  logic              xtal_tick,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              losc_clk_en,
    output logic              rtc_clk_en,
    output logic              fanout_clk_en
);
    ctrl_t             ctrl;
    gate_t             gate;
    logic [DIVN_W-1:0] divn;
    logic              fast_en;
    logic              div_wr;
    logic              fast_pulse;
    logic              ref_pulse;
    logic              xtal_gated;
    logic              fo_mux;

    rtc32k_regs #(.DIVN_W(DIVN_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .ctrl_o    (ctrl),
        .gate_o    (gate),
        .divn_o    (divn),
        .fast_en_o (fast_en),
        .div_wr_o  (div_wr)
    );

    rtc32k_fast_div #(.PRE_DIV(PRE_DIV), .DIVN_W(DIVN_W)) u_fast (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (fast_en),
        .restart (div_wr),
        .tick    (fast_tick),
        .divn    (divn),
        .pulse   (fast_pulse)
    );

    rtc32k_fixed_div #(.DIV(REF_DIV)) u_ref (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (gate.ref_gate),
        .tick  (ref_tick),
        .pulse (ref_pulse)
    );

    generate
        if (HAS_EXT_XTAL) begin : g_xtal
            assign xtal_gated = xtal_tick && ctrl.xtal_gate;
        end else begin : g_no_xtal
            logic unused_xtal;
            assign unused_xtal = xtal_tick ^ ctrl.xtal_gate;
            assign xtal_gated  = 1'b0;
        end
    endgenerate

    always_comb begin
        losc_clk_en = ctrl.losc_sel ? xtal_gated : fast_pulse;
        rtc_clk_en  = ctrl.rtc_sel  ? ref_pulse  : losc_clk_en;
        unique case (gate.fo_src)
            FO_LOSC: fo_mux = losc_clk_en;
            FO_XTAL: fo_mux = xtal_gated;
            FO_REF:  fo_mux = ref_pulse;
            default: fo_mux = 1'b0;
        endcase
        fanout_clk_en = gate.fo_en && fo_mux;
    end
endmodule

// File: rtl/rtc32k_clk_sel_chk.sv
module rtc32k_clk_sel_chk
    import rtc32k_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input ctrl_t             ctrl,
    input gate_t             gate,
    input logic              fast_en,
    input logic              fast_pulse,
    input logic              ref_pulse,
    input logic              losc_clk_en,
    input logic              rtc_clk_en,
    input logic              fanout_clk_en
);
    AST_CTRL_KEY_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFF_CTRL && reg_wdata[31:16] != CTRL_KEY) |=> $stable(ctrl)); // R2
    AST_FAST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !fast_en |-> !fast_pulse); // R4
    AST_REF_GATE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !gate.ref_gate |-> !ref_pulse); // R6
    AST_RTC_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        rtc_clk_en |-> (ctrl.rtc_sel ? ref_pulse : losc_clk_en)); // R8
    AST_FANOUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        fanout_clk_en |-> (gate.fo_en && gate.fo_src != FO_NONE)); // R9
endmodule

bind rtc32k_clk_sel rtc32k_clk_sel_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_we        (reg_we),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .ctrl          (ctrl),
    .gate          (gate),
    .fast_en       (fast_en),
    .fast_pulse    (fast_pulse),
    .ref_pulse     (ref_pulse),
    .losc_clk_en   (losc_clk_en),
    .rtc_clk_en    (rtc_clk_en),
    .fanout_clk_en (fanout_clk_en)
);

// File: tb/tb_rtc32k_clk_sel.sv
module tb_rtc32k_clk_sel;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fast_tick = 1'b0;
    logic        ref_tick = 1'b0;
    logic        xtal_tick = 1'b0;
    logic        reg_we = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        losc_clk_en, rtc_clk_en, fanout_clk_en;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    int n_rtc, n_losc, n_fo, first_rtc, first_losc;

    rtc32k_clk_sel dut (
        .clk(clk), .rst_n(rst_n), .fast_tick(fast_tick), .ref_tick(ref_tick),
        .xtal_tick(xtal_tick), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .losc_clk_en(losc_clk_en),
        .rtc_clk_en(rtc_clk_en), .fanout_clk_en(fanout_clk_en)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_check(input logic [8:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #(PERIOD/4);
        check(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    task automatic run(input bit f, input bit r, input bit x, input int n);
        n_rtc = 0; n_losc = 0; n_fo = 0; first_rtc = -1; first_losc = -1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            fast_tick = f; ref_tick = r; xtal_tick = x;
            #(PERIOD/4);
            if (rtc_clk_en)  begin n_rtc++;  if (first_rtc < 0)  first_rtc = i;  end
            if (losc_clk_en) begin n_losc++; if (first_losc < 0) first_losc = i; end
            if (fanout_clk_en) n_fo++;
        end
        @(negedge clk);
        fast_tick = 1'b0; ref_tick = 1'b0; xtal_tick = 1'b0;
    endtask

    task automatic t_reset();
        rd_check(9'h000, 32'h0, "R1");
        rd_check(9'h008, 32'h0, "R1");
        rd_check(9'h060, 32'h0, "R1");
        rd_check(9'h160, 32'h0, "R1");
        run(1'b1, 1'b1, 1'b1, 100);
        check(n_rtc == 0 && n_losc == 0 && n_fo == 0, "R1", n_rtc + n_losc + n_fo, 0);
    endtask

    task automatic t_key();
        wr(9'h000, 32'h0000_0013);
        rd_check(9'h000, 32'h0, "R2");
        wr(9'h000, 32'h16AA_0013);
        rd_check(9'h000, 32'h13, "R2");
        wr(9'h000, 32'h16AB_0000);
        rd_check(9'h000, 32'h13, "R2");
        wr(9'h000, 32'h16AA_0000);
        rd_check(9'h000, 32'h0, "R2");
    endtask

    task automatic t_fast_div();
        wr(9'h160, 32'h1);
        wr(9'h008, 32'h2);
        run(1'b1, 1'b0, 1'b0, 192);
        check(n_rtc == 2, "R3", n_rtc, 2);
        check(first_rtc == 95, "R3", first_rtc, 95);
        check(n_losc == 2, "R7", n_losc, 2);
        wr(9'h008, 32'h0);
        run(1'b1, 1'b0, 1'b0, 64);
        check(n_rtc == 2 && first_rtc == 31, "R3", first_rtc, 31);
    endtask

    task automatic t_restart();
        wr(9'h008, 32'h1);
        run(1'b1, 1'b0, 1'b0, 40);
        wr(9'h008, 32'h1);
        run(1'b1, 1'b0, 1'b0, 63);
        check(n_losc == 0, "R5", n_losc, 0);
        run(1'b1, 1'b0, 1'b0, 1);
        check(n_losc == 1, "R5", n_losc, 1);
    endtask

    task automatic t_disable();
        run(1'b1, 1'b0, 1'b0, 20);
        wr(9'h160, 32'h0);
        run(1'b1, 1'b0, 1'b0, 200);
        check(n_losc == 0, "R4", n_losc, 0);
        wr(9'h160, 32'h1);
        run(1'b1, 1'b0, 1'b0, 64);
        check(first_losc == 63, "R4", first_losc, 63);
        wr(9'h160, 32'h0);
    endtask

    task automatic t_ref();
        wr(9'h000, 32'h16AA_0002);
        run(1'b0, 1'b1, 1'b0, 1500);
        check(n_rtc == 0, "R6", n_rtc, 0);
        wr(9'h060, 32'h0001_0000);
        run(1'b0, 1'b1, 1'b0, 1500);
        check(n_rtc == 2, "R6", n_rtc, 2);
        check(first_rtc == 749, "R6", first_rtc, 749);
        check(n_losc == 0, "R8", n_losc, 0);
        wr(9'h060, 32'h0);
    endtask

    task automatic t_xtal();
        wr(9'h000, 32'h16AA_0011);
        run(1'b0, 1'b0, 1'b1, 10);
        check(n_losc == 10, "R7", n_losc, 10);
        check(n_rtc == 10, "R8", n_rtc, 10);
        wr(9'h000, 32'h16AA_0001);
        run(1'b0, 1'b0, 1'b1, 10);
        check(n_losc == 0, "R7", n_losc, 0);
    endtask

    task automatic t_fanout();
        wr(9'h000, 32'h16AA_0011);
        wr(9'h060, 32'h0000_0001);
        run(1'b0, 1'b0, 1'b1, 10);
        check(n_fo == 10, "R9", n_fo, 10);
        wr(9'h060, 32'h0000_0003);
        run(1'b0, 1'b0, 1'b1, 10);
        check(n_fo == 10, "R9", n_fo, 10);
        wr(9'h060, 32'h0001_0005);
        run(1'b0, 1'b1, 1'b1, 750);
        check(n_fo == 1, "R9", n_fo, 1);
        wr(9'h060, 32'h0001_0007);
        run(1'b0, 1'b1, 1'b1, 750);
        check(n_fo == 0, "R9", n_fo, 0);
        wr(9'h060, 32'h0000_0002);
        run(1'b0, 1'b0, 1'b1, 10);
        check(n_fo == 0, "R9", n_fo, 0);
    endtask

    task automatic t_readback();
        rd_check(9'h004, 32'h0, "R10");
        wr(9'h008, 32'hFFFF_FFFF);
        rd_check(9'h008, 32'h1F, "R10");
        wr(9'h160, 32'hFFFF_FFFF);
        rd_check(9'h160, 32'h1, "R10");
        wr(9'h060, 32'hFFFF_FFFF);
        rd_check(9'h060, 32'h0001_0007, "R10");
        wr(9'h000, 32'h16AA_FFFF);
        rd_check(9'h000, 32'h13, "R10");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_key();
        t_fast_div();
        t_restart();
        t_disable();
        t_ref();
        t_xtal();
        t_fanout();
        t_readback();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule